// File: doc/BRIEF.md
# Reload-and-Match PWM Timer

This block is an up-counting timer that makes a pulse-width-modulated waveform. The period is set by a reload value: the counter climbs from that value to the all-ones count, then wraps back to it. The wrap is the overflow event, and it drives the output to its active level. When the count reaches a programmed match value, the output returns to its inactive level. The active time is therefore set by match minus load, and the period by the distance from load to all-ones.

Software controls the block with write strobes. It can write the load value, the match value and the counter, start or stop the timer, and set the output polarity. It reads back a running flag, the current polarity, the live count and a flag that marks an illegal load/match pair. One-clock overflow and match pulses are also brought out, so event timing can be seen from outside. Load and match writes land at once with no shadow copy. A write in the middle of a period therefore bends that period.

Top module: `pwm_reload_timer`

## Requirements
- R1: After reset the timer is stopped, the count is 0, polarity is normal (`pol_state`=0), `pwm_out` is 0 and `cfg_err` is 0 (load = match = 0 is legal).
- R2: A start pulse while stopped sets `running` and preloads the count with all-ones minus one. The next edge takes the count to all-ones. `ovf_pulse` is high during that cycle, and the output turns active on the following edge.
- R3: In every cycle where the timer runs and the count is all-ones, `ovf_pulse` is 1. At the next edge the count reloads with the load value and the output becomes active.
- R4: `match_pulse` is 1 while the timer runs and the count equals match. After that edge the output is inactive. The active time is match − load + 1 clocks, the inactive time is all-ones − match clocks, and the period is all-ones − load + 1 clocks.
- R5: When load equals match, the output is active for exactly one clock per period.
- R6: `cfg_err` is 1 exactly when the pair is not load ≤ match < all-ones.
- R7: A stop pulse halts the counter at once, holding its value, clears `running`, and forces the output inactive on the same edge. Stop wins over a start in the same cycle.
- R8: `pwm_out` is the active-high waveform XOR polarity, so with polarity 1 the output idles high and is low while active. A polarity write is taken only while stopped; a write while running leaves `pol_state` unchanged.
- R9: A counter write is taken only while stopped. While running it is ignored and the count keeps incrementing.
- R10: Load and match writes take effect at the next edge, with no shadowing. Raising match during the active phase lengthens the current active time to new match − load + 1.
- R11: A start pulse while running is ignored: the count is not preloaded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_we | input | 1 | Write strobe for the load value |
| load_wdata | input | WIDTH | New load value |
| match_we | input | 1 | Write strobe for the match value |
| match_wdata | input | WIDTH | New match value |
| cnt_we | input | 1 | Counter write strobe (taken only while stopped) |
| cnt_wdata | input | WIDTH | New counter value |
| start | input | 1 | Start pulse |
| stop | input | 1 | Stop pulse |
| pol_we | input | 1 | Polarity write strobe (taken only while stopped) |
| pol_wdata | input | 1 | New polarity, 1 = inverted |
| pwm_out | output | 1 | PWM waveform |
| running | output | 1 | Status: timer is counting |
| pol_state | output | 1 | Status: current polarity |
| cfg_err | output | 1 | Load/match pair is illegal |
| count | output | WIDTH | Live counter value |
| ovf_pulse | output | 1 | One-clock overflow event |
| match_pulse | output | 1 | One-clock match event |

## Verification
The hardest case to reach from the ports is a period that mixes old and new settings. The match write has to land in the window after the reload and before the old match compare. The stimulus waits for `ovf_pulse`, moves one cycle into the active phase, writes a larger match there, and then counts active cycles until the new compare. The same synchronisation on `ovf_pulse` places the stop, the start-while-running and the counter-write-while-running pulses inside a known phase, where the expected count is exact.

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_we,
  input  logic [WIDTH-1:0] load_wdata,
  input  logic             match_we,
  input  logic [WIDTH-1:0] match_wdata,
  input  logic             cnt_we,
  input  logic [WIDTH-1:0] cnt_wdata,
  input  logic             start,
  input  logic             stop,
  input  logic             pol_we,
  input  logic             pol_wdata,
  output logic             pwm_out,
  output logic             running,
  output logic             pol_state,
  output logic             cfg_err,
  output logic [WIDTH-1:0] count,
  output logic             ovf_pulse,
  output logic             match_pulse
);

  localparam logic [WIDTH-1:0] ALL_ONES = '1;
  localparam logic [WIDTH-1:0] PRELOAD  = ALL_ONES - 1'b1;

  logic [WIDTH-1:0] load_q, match_q, cnt_q;
  logic             run_q, act_q, pol_q;

  assign ovf_pulse   = run_q && (cnt_q == ALL_ONES);
  assign match_pulse = run_q && (cnt_q == match_q);
  assign cfg_err     = (load_q > match_q) || (match_q == ALL_ONES);
  assign pwm_out     = act_q ^ pol_q;
  assign running     = run_q;
  assign pol_state   = pol_q;
  assign count       = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q  <= '0;
      match_q <= '0;
    end else begin
      if (load_we)  load_q  <= load_wdata;
      if (match_we) match_q <= match_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      pol_q <= 1'b0;
    end else begin
      if (stop)                run_q <= 1'b0;
      else if (start && !run_q) run_q <= 1'b1;
      if (!run_q && pol_we)    pol_q <= pol_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run_q) begin
      if (start && !stop) cnt_q <= PRELOAD;
      else if (cnt_we)    cnt_q <= cnt_wdata;
    end else if (!stop) begin
      cnt_q <= ovf_pulse ? load_q : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               act_q <= 1'b0;
    else if (!run_q || stop)  act_q <= 1'b0;
    else if (ovf_pulse)       act_q <= 1'b1;
    else if (match_pulse)     act_q <= 1'b0;
  end

  p_preload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop && !running) |=> (running && count == PRELOAD));

  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_pulse && !stop) |=> (count == $past(load_q) && pwm_out != pol_state));

  p_match_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (match_pulse && !ovf_pulse && !stop) |=> (pwm_out == pol_state));

  p_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!running && $stable(count) && pwm_out == pol_state));

  p_pol_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> $stable(pol_state));

  p_cnt_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !stop && !ovf_pulse) |=> (count == $past(count) + 1'b1));

endmodule

// File: tb/test_pwm_reload_timer.sv
module test_pwm_reload_timer;
  localparam int W = 32;
  localparam logic [W-1:0] MAX = '1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic load_we = 0, match_we = 0, cnt_we = 0, start = 0, stop = 0, pol_we = 0, pol_wdata = 0;
  logic [W-1:0] load_wdata = '0, match_wdata = '0, cnt_wdata = '0;
  logic pwm_out, running, pol_state, cfg_err, ovf_pulse, match_pulse;
  logic [W-1:0] count;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm_reload_timer #(.WIDTH(W)) i_pwm_reload_timer (
    .clk(clk), .rst_n(rst_n),
    .load_we(load_we), .load_wdata(load_wdata),
    .match_we(match_we), .match_wdata(match_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .start(start), .stop(stop), .pol_we(pol_we), .pol_wdata(pol_wdata),
    .pwm_out(pwm_out), .running(running), .pol_state(pol_state),
    .cfg_err(cfg_err), .count(count), .ovf_pulse(ovf_pulse), .match_pulse(match_pulse));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_lm(input logic [W-1:0] l, input logic [W-1:0] m);
    @(negedge clk);
    load_we = 1; load_wdata = l; match_we = 1; match_wdata = m;
    @(negedge clk);
    load_we = 0; match_we = 0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop = 1; @(negedge clk); stop = 0;
  endtask

  task automatic sync_ovf();
    int g = 0;
    @(negedge clk);
    while (!ovf_pulse && g < 1000) begin @(negedge clk); g++; end
    @(negedge clk);
  endtask

  task automatic measure(output int hi, output int lo);
    sync_ovf();
    hi = 0; lo = 0;
    while (pwm_out != pol_state && hi < 1000) begin hi++; @(negedge clk); end
    while (pwm_out == pol_state && lo < 1000) begin lo++; @(negedge clk); end
  endtask

  task automatic t_reset();
    chk(!running, "R1 running", running, 0);
    chk(count == 0, "R1 count", count, 0);
    chk(!pol_state && !pwm_out, "R1 pol/out", {pol_state, pwm_out}, 0);
    chk(!cfg_err, "R1 cfg_err", cfg_err, 0);
  endtask

  task automatic t_start();
    set_lm(MAX - 9, MAX - 6);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(running && count == MAX - 1, "R2 preload", count, MAX - 1);
    chk(!ovf_pulse && !pwm_out, "R2 idle first", {ovf_pulse, pwm_out}, 0);
    @(negedge clk);
    chk(ovf_pulse && count == MAX && !pwm_out, "R2 ovf cycle", {ovf_pulse, pwm_out}, 2);
    @(negedge clk);
    chk(pwm_out && count == MAX - 9, "R3 reload active", count, MAX - 9);
  endtask

  task automatic t_period(input logic [W-1:0] l, input logic [W-1:0] m, input string req);
    int hi, lo;
    set_lm(l, m);
    measure(hi, lo);
    measure(hi, lo);
    chk(hi == int'(m - l + 1), {req, " active"}, hi, m - l + 1);
    chk(lo == int'(MAX - m), {req, " inactive"}, lo, MAX - m);
  endtask

  task automatic t_match_pulse();
    int g = 0;
    sync_ovf();
    while (!match_pulse && g < 100) begin @(negedge clk); g++; end
    chk(count == MAX - 6 && pwm_out, "R4 match pulse", count, MAX - 6);
    @(negedge clk);
    chk(!pwm_out, "R4 off after match", pwm_out, 0);
  endtask

  task automatic t_cfg();
    set_lm(10, 5);
    chk(cfg_err, "R6 load>match", cfg_err, 1);
    set_lm(10, MAX);
    chk(cfg_err, "R6 match=max", cfg_err, 1);
    set_lm(10, 10);
    chk(!cfg_err, "R6 legal", cfg_err, 0);
    set_lm(MAX - 9, MAX - 6);
  endtask

  task automatic t_mixed();
    int hi;
    sync_ovf();
    match_we = 1; match_wdata = MAX - 3; hi = 1;
    @(negedge clk); match_we = 0;
    while (pwm_out != pol_state && hi < 1000) begin hi++; @(negedge clk); end
    chk(hi == 7, "R10 mixed active", hi, 7);
    set_lm(MAX - 9, MAX - 6);
  endtask

  task automatic t_ignore_running();
    logic [W-1:0] c;
    sync_ovf();
    c = count; start = 1;
    @(negedge clk); start = 0;
    chk(count == c + 1, "R11 start ignored", count, c + 1);
    c = count; cnt_we = 1; cnt_wdata = 32'h5;
    @(negedge clk); cnt_we = 0;
    chk(count == c + 1, "R9 cnt write ignored", count, c + 1);
    pol_we = 1; pol_wdata = 1;
    @(negedge clk); pol_we = 0;
    chk(!pol_state, "R8 pol write ignored", pol_state, 0);
  endtask

  task automatic t_stop();
    logic [W-1:0] c;
    sync_ovf();
    @(negedge clk);
    c = count; stop = 1; start = 1;
    @(negedge clk); stop = 0; start = 0;
    chk(!running && count == c, "R7 halt", count, c);
    chk(!pwm_out, "R7 inactive", pwm_out, 0);
    repeat (3) @(negedge clk);
    chk(count == c, "R7 held", count, c);
  endtask

  task automatic t_cnt_write();
    @(negedge clk); cnt_we = 1; cnt_wdata = 32'h1234;
    @(negedge clk); cnt_we = 0;
    chk(count == 32'h1234 && !running, "R9 cnt write stopped", count, 32'h1234);
  endtask

  task automatic t_polarity();
    int hi, lo;
    @(negedge clk); pol_we = 1; pol_wdata = 1;
    @(negedge clk); pol_we = 0;
    chk(pol_state && pwm_out, "R8 inverted idle", {pol_state, pwm_out}, 3);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    measure(hi, lo);
    chk(hi == 4 && lo == 6, "R8 inverted wave", {hi, lo}, {32'd4, 32'd6});
    pulse_stop();
    chk(pwm_out, "R8 inverted stop", pwm_out, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_start();
    t_period(MAX - 9, MAX - 6, "R4");
    t_period(MAX - 19, MAX - 5, "R4 long");
    t_period(MAX - 7, MAX - 7, "R5");
    set_lm(MAX - 9, MAX - 6);
    t_match_pulse();
    t_mixed();
    t_ignore_running();
    t_cfg();
    t_stop();
    t_cnt_write();
    t_polarity();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule